// File: doc/BRIEF.md
# UART Data Register Buffer Front-End

This block is the register-side data path of a serial port. A CPU-style register bus reaches it through one data-register select, a read strobe, a write strobe and byte-wide data. A write at that select lands in a transmit holding buffer. A read at the same select returns, and consumes, the oldest byte of a small receive FIFO.

The holding buffer hands its byte to the transmit shifter as soon as the shifter is idle and transmission is enabled. The receive FIFO is filled by the receive shifter, one strobe per character. The block flags when the holding buffer can take a byte, when received data is waiting, and when a received character was lost because the FIFO was full.

A two-bit character-size input selects 5, 6, 7 or 8 data bits. Unused upper bits are cleared on both the transmit and the receive side.

Top module: `uart_dbuf`

## Requirements
- R1: A write (`dr_sel` and `bus_wr`) loads only the transmit holding buffer, and `bus_rdata` always shows the receive side. A write, including one made in the same cycle as a read, never alters what `bus_rdata` returns.
- R2: A write is taken only while `dreg_empty` is 1. A write made while `dreg_empty` is 0 is discarded: the byte held before it is the one later handed to the shifter.
- R3: An accepted write drives `dreg_empty` to 0 from the next cycle. When the buffer is full, `tx_enable` is 1 and `shifter_idle` is 1, `shifter_load` is 1 in that same cycle with the held byte on `shifter_data`, and `dreg_empty` returns to 1 in the next cycle.
- R4: The receive side is a FIFO of `RX_DEPTH` entries (default 2). `bus_rdata` shows its oldest entry combinationally. Every read access (`dr_sel` and `bus_rd`) that finds the FIFO non-empty removes one entry, whatever the purpose of the read.
- R5: `char_size` 2'b00, 2'b01, 2'b10 and 2'b11 select 5, 6, 7 and 8 data bits. The transmit byte is masked to that width when it is written. A received byte is masked to that width when it is pushed.
- R6: `rx_ready` is 1 exactly while the FIFO holds at least one entry, starting the cycle after the push.
- R7: A read of an empty FIFO removes nothing. `bus_rdata` then shows the byte most recently removed, or 0 if none has been removed since reset.
- R8: A character strobed in while the FIFO is full, with no read in that cycle, is dropped. `rx_overrun` goes to 1 the next cycle and stays at 1 until the next read access, which clears it for the following cycle.
- R9: While `tx_enable` is 0, `shifter_load` stays 0 and the held byte is kept.
- R10: A push and a read in the same cycle on a full FIFO both take effect: the oldest entry leaves, the new one enters, and no overrun is flagged.
- R11: Reset (`rst_n` low at a clock edge) leaves `dreg_empty` at 1, `rx_ready`, `rx_overrun` and `shifter_load` at 0, and `bus_rdata` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dr_sel | input | 1 | Data register address selected |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Oldest received byte (or last removed byte when empty) |
| char_size | input | 2 | Character size: 00=5, 01=6, 10=7, 11=8 bits |
| tx_enable | input | 1 | Transmitter enabled |
| shifter_idle | input | 1 | Transmit shift register is empty |
| shifter_load | output | 1 | Load pulse into the transmit shift register |
| shifter_data | output | 8 | Byte handed to the transmit shift register |
| rx_strobe | input | 1 | Receive shifter delivers a character |
| rx_char | input | 8 | Character from the receive shifter |
| dreg_empty | output | 1 | Holding buffer can take a write |
| rx_ready | output | 1 | Receive FIFO holds data |
| rx_overrun | output | 1 | Sticky: a received character was dropped |

## Verification
`shifter_load`, `shifter_data` and `bus_rdata` respond in the same cycle as their inputs. They are checked 1 ns after the inputs change, in the low half of the clock. `dreg_empty`, `rx_ready` and `rx_overrun` change at the clock edge that follows the stimulus, so each is compared one cycle after it. The reference model advances its state only at the rising edge, from the same inputs the design sampled there, so every comparison lines up with the register that drives it. Directed sequences cover full-buffer writes, overrun and its clearing, simultaneous push and pop, empty reads and every character size. A stretch of randomly mixed traffic follows, compared on every clock.

// File: rtl/uart_dbuf_pkg.sv
// Shared types and helpers for the UART data buffer front-end.
// Assumes an 8-bit register bus and character sizes from 5 up to 8 bits.
package uart_dbuf_pkg;
    localparam int DW       = 8;
    localparam int MIN_BITS = 5;

    typedef logic [DW-1:0] char_t;

    // Keep-mask for a 2-bit character size code (00 -> MIN_BITS bits).
    function automatic char_t char_mask(input logic [1:0] size_code);
        char_t m;
        int    nbits;
        nbits = MIN_BITS + int'(size_code);
        for (int i = 0; i < DW; i++) begin
            m[i] = (i < nbits);
        end
        return m;
    endfunction
endpackage

// File: rtl/uart_tx_hold.sv
// Single-entry transmit holding buffer.
// Takes a byte only while it is empty and passes it to the shifter when the
// shifter is idle and transmission is enabled. Input data arrives pre-masked.
module uart_tx_hold
    import uart_dbuf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_i,
    input  char_t data_i,
    input  logic  tx_en_i,
    input  logic  sh_idle_i,
    output logic  empty_o,
    output logic  load_o,
    output char_t data_o
);
    logic  full_q;
    char_t hold_q;

    // Handover happens when there is a byte and the shifter can take it.
    assign load_o  = full_q && tx_en_i && sh_idle_i;
    assign empty_o = !full_q;
    assign data_o  = hold_q;

    // Buffer state: a handover frees it, a write only lands when it is free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            hold_q <= '0;
        end else if (load_o) begin
            full_q <= 1'b0;
        end else if (wr_i && !full_q) begin
            full_q <= 1'b1;
            hold_q <= data_i;
        end
    end

    p_drop_when_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && full_q && !load_o) |=> (full_q && $stable(hold_q)));

    p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && empty_o) |=> (!empty_o && data_o == $past(data_i)));

    p_load_frees_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> empty_o);

    p_hold_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !tx_en_i) |=> (full_q && $stable(hold_q)));
endmodule

// File: rtl/uart_rx_fifo.sv
// Receive FIFO with a sticky overrun flag.
// Any read access pops when non-empty. An empty read shows the last popped
// byte. A push into a full FIFO is kept only if a pop happens in that cycle.
module uart_rx_fifo
    import uart_dbuf_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push_i,
    input  char_t push_data_i,
    input  logic  rd_i,
    output char_t head_o,
    output logic  nonempty_o,
    output logic  overrun_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

    char_t          mem [DEPTH];
    logic [PW-1:0]  wp_q, rp_q;
    logic [CW-1:0]  cnt_q;
    char_t          last_q;
    logic           ovr_q;
    logic           full, pop, push_ok, drop;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PW'(1);
    endfunction

    // Decide pop, accepted push and dropped push for this cycle.
    always_comb begin
        full    = (cnt_q == FULL_CNT);
        pop     = rd_i && (cnt_q != '0);
        push_ok = push_i && (!full || pop);
        drop    = push_i && full && !pop;
    end

    assign head_o     = (cnt_q != '0) ? mem[rp_q] : last_q;
    assign nonempty_o = (cnt_q != '0);
    assign overrun_o  = ovr_q;

    // Entry storage: write the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push_ok) begin
            mem[wp_q] <= push_data_i;
        end
    end

    // Pointers and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wp_q <= ptr_next(wp_q);
            if (pop)     rp_q <= ptr_next(rp_q);
            case ({push_ok, pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Last popped byte, shown when the FIFO is empty.
    always_ff @(posedge clk) begin
        if (!rst_n)   last_q <= '0;
        else if (pop) last_q <= mem[rp_q];
    end

    // Sticky overrun: set by a dropped push, cleared by any read access.
    always_ff @(posedge clk) begin
        if (!rst_n)     ovr_q <= 1'b0;
        else if (rd_i)  ovr_q <= 1'b0;
        else if (drop)  ovr_q <= 1'b1;
    end

    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);

    p_push_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !nonempty_o) |=> nonempty_o);

    p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !nonempty_o && !push_i) |=> ($stable(head_o) && !nonempty_o));

    p_drop_sets_ovr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full && !rd_i) |=> overrun_o);

    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && !rd_i) |=> overrun_o);

    p_swap_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && rd_i && full) |=> (cnt_q == FULL_CNT && !overrun_o));
endmodule

// File: rtl/uart_dbuf.sv
// UART data register front-end: one bus address, a write-side holding buffer
// toward the transmit shifter and a read-side FIFO from the receive shifter.
// Assumes dr_sel already decodes the data register address.
module uart_dbuf
    import uart_dbuf_pkg::*;
#(
    parameter int RX_DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dr_sel,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [1:0]    char_size,
    input  logic          tx_enable,
    input  logic          shifter_idle,
    output logic          shifter_load,
    output logic [DW-1:0] shifter_data,
    input  logic          rx_strobe,
    input  logic [DW-1:0] rx_char,
    output logic          dreg_empty,
    output logic          rx_ready,
    output logic          rx_overrun
);
    char_t keep_mask;
    logic  wr_acc, rd_acc;

    // Decode bus accesses and the character-width mask.
    always_comb begin
        keep_mask = char_mask(char_size);
        wr_acc    = dr_sel && bus_wr;
        rd_acc    = dr_sel && bus_rd;
    end

    uart_tx_hold u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_acc),
        .data_i    (bus_wdata & keep_mask),
        .tx_en_i   (tx_enable),
        .sh_idle_i (shifter_idle),
        .empty_o   (dreg_empty),
        .load_o    (shifter_load),
        .data_o    (shifter_data)
    );

    uart_rx_fifo #(.DEPTH(RX_DEPTH)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (rx_strobe),
        .push_data_i (rx_char & keep_mask),
        .rd_i        (rd_acc),
        .head_o      (bus_rdata),
        .nonempty_o  (rx_ready),
        .overrun_o   (rx_overrun)
    );

    p_write_isolated_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && !rd_acc && !rx_strobe) |=> $stable(bus_rdata));
endmodule

// File: tb/sim_uart_dbuf.sv
// Bench for uart_dbuf: behavioural reference model (queue, flags) compared
// every clock. Inputs change at the falling edge and are checked 1 ns later.
module sim_uart_dbuf;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       s = 0, rd = 0, wr = 0, rv = 0, te = 0, se = 1;
    logic [7:0] wd = 0, rdin = 0;
    logic [1:0] cs = 2'b11;
    logic [7:0] bus_rdata, shifter_data;
    logic       shifter_load, dreg_empty, rx_ready, rx_overrun;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [7:0] q[$];
    logic [7:0] m_hold = 0, m_last = 0;
    logic       m_full = 0, m_ovr = 0;

    always #2 clk = ~clk;

    uart_dbuf u0 (
        .clk(clk), .rst_n(rst_n), .dr_sel(s), .bus_rd(rd), .bus_wr(wr),
        .bus_wdata(wd), .bus_rdata(bus_rdata), .char_size(cs),
        .tx_enable(te), .shifter_idle(se), .shifter_load(shifter_load),
        .shifter_data(shifter_data), .rx_strobe(rv), .rx_char(rdin),
        .dreg_empty(dreg_empty), .rx_ready(rx_ready), .rx_overrun(rx_overrun)
    );

    function automatic logic [7:0] bmask(input logic [1:0] c);
        case (c)
            2'b00:   return 8'h1F;
            2'b01:   return 8'h3F;
            2'b10:   return 8'h7F;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare outputs, advance one clock, update the model, clear strobes.
    task automatic tick();
        logic       exp_load;
        logic [7:0] exp_rd;
        logic       pop;
        #1;
        exp_load = m_full && te && se;
        exp_rd   = (q.size() > 0) ? q[0] : m_last;
        chk("R3 dreg_empty", {7'd0, dreg_empty}, {7'd0, !m_full});
        chk("R6 rx_ready", {7'd0, rx_ready}, {7'd0, q.size() > 0});
        chk("R8 rx_overrun", {7'd0, rx_overrun}, {7'd0, m_ovr});
        chk("R4 bus_rdata", bus_rdata, exp_rd);
        chk("R9 shifter_load", {7'd0, shifter_load}, {7'd0, exp_load});
        if (exp_load) chk("R5 shifter_data", shifter_data, m_hold);
        @(posedge clk);
        pop = s && rd && (q.size() > 0);
        if (s && rd) m_ovr = 1'b0;
        if (pop) m_last = q.pop_front();
        if (rv) begin
            if (q.size() < 2) q.push_back(rdin & bmask(cs));
            else m_ovr = 1'b1;
        end
        if (exp_load) m_full = 1'b0;
        else if (s && wr && !m_full) begin
            m_full = 1'b1;
            m_hold = wd & bmask(cs);
        end
        @(negedge clk);
        s = 0; rd = 0; wr = 0; rv = 0;
    endtask

    task automatic do_write(input logic [7:0] d);
        s = 1; wr = 1; wd = d; tick();
    endtask

    task automatic do_read();
        s = 1; rd = 1; tick();
    endtask

    task automatic do_push(input logic [7:0] d);
        rv = 1; rdin = d; tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired, all requirements: actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11: state after reset
        chk("R11 dreg_empty", {7'd0, dreg_empty}, 8'd1);
        chk("R11 rx_ready", {7'd0, rx_ready}, 8'd0);
        chk("R11 rx_overrun", {7'd0, rx_overrun}, 8'd0);
        chk("R11 bus_rdata", bus_rdata, 8'h00);
        chk("R11 shifter_load", {7'd0, shifter_load}, 8'd0);
        @(negedge clk);

        // R9: disabled transmitter keeps its byte
        cs = 2'b11; te = 0; se = 1;
        do_write(8'hA5);
        tick(); tick();
        // R2: write while full is dropped
        do_write(8'h3C);
        // R3: enable -> load of A5 same cycle, empty next cycle
        te = 1;
        tick(); tick();
        // R3: busy shifter delays the handover
        se = 0;
        do_write(8'h77);
        tick();
        se = 1;
        tick(); tick();
        // R5: transmit masking for each size
        for (int c = 0; c < 4; c++) begin
            cs = 2'(c);
            do_write(8'hFF);
            tick();
        end

        // R4, R8: fill, overrun, sticky, clear on read
        cs = 2'b11;
        do_push(8'h11);
        do_push(8'h22);
        do_push(8'h33);
        tick();
        do_read();
        do_read();
        // R7: empty reads keep showing the last popped byte
        do_read();
        do_read();
        tick();

        // R10: push and pop together on a full FIFO
        do_push(8'h44);
        do_push(8'h55);
        s = 1; rd = 1; rv = 1; rdin = 8'h66; tick();
        tick();
        do_read();
        do_read();

        // R5: receive masking for each size
        for (int c = 0; c < 4; c++) begin
            cs = 2'(c);
            do_push(8'hFF);
            do_read();
        end

        // R1: write and read in the same cycle stay apart
        cs = 2'b11; te = 0;
        do_push(8'h5A);
        s = 1; wr = 1; rd = 1; wd = 8'h99; tick();
        tick();
        te = 1;
        tick(); tick();

        // mixed traffic, all requirements compared every clock
        for (int i = 0; i < 600; i++) begin
            s    = ($urandom % 4) != 0;
            rd   = ($urandom % 3) == 0;
            wr   = ($urandom % 3) == 0;
            wd   = 8'($urandom);
            rv   = ($urandom % 3) == 0;
            rdin = 8'($urandom);
            te   = ($urandom % 4) != 0;
            se   = ($urandom % 2) != 0;
            cs   = 2'($urandom);
            tick();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule